// File: doc/BRIEF.md
# Byte-Lane Parity and Endian Formatter

This block is a registered datapath stage for words built from four 9-bit lanes. Each lane holds 8 data bits with a parity bit above them. The stage has two independent paths that share one set of configuration inputs.

The ingress path can compute the parity bit of every lane and write it into that lane's top bit. The egress path checks parity on every lane and can reverse the lane order, which converts between big-endian and little-endian layouts. It reports a per-lane error vector and a single combined error flag.

One polarity input selects odd parity, the default at 0, or even parity. Generation and checking both use it. Each path registers its result, so the result appears one clock after its input valid.

Top module: `blf_fmt`

## Requirements
- R1: While reset is held, and in the first cycle after it, every output is zero: ing_vld, ing_word, eg_vld, eg_word, eg_lane_err and eg_perr.
- R2: With cfg_gen_en=1, bit 9k+8 of ing_word is replaced by a parity bit over bits 9k+7..9k. With cfg_even=0 the parity bit makes the number of ones in the 9-bit lane odd. With cfg_even=1 it makes that number even. Bits 9k+7..9k are copied unchanged.
- R3: With cfg_gen_en=0, the accepted ingress word appears on ing_word unchanged, including its lane top bits.
- R4: ing_vld equals ing_in_vld of the previous cycle. When ing_in_vld was 0, ing_word keeps its value.
- R5: eg_lane_err[i] is 1 exactly when lane i of the registered eg_word fails the parity check. A lane fails when its 9-bit ones count is even under cfg_even=0, or odd under cfg_even=1.
- R6: eg_perr is 1 exactly when at least one of the four lanes of the registered egress word failed. It changes in the same cycle as eg_word.
- R7: With cfg_rev_en=1, eg_word lane 0 is input lane 3, lane 1 is input lane 2, lane 2 is input lane 1 and lane 3 is input lane 0. Lane i occupies bits 9i+8..9i.
- R8: With cfg_rev_en=0, the accepted egress word appears on eg_word unchanged.
- R9: eg_vld equals eg_in_vld of the previous cycle. When eg_in_vld was 0, eg_word, eg_lane_err and eg_perr keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| cfg_even | input | 1 | Parity polarity: 0 selects odd, 1 selects even |
| cfg_gen_en | input | 1 | Enables parity generation on the ingress path |
| cfg_rev_en | input | 1 | Enables lane reversal on the egress path |
| ing_in_vld | input | 1 | Ingress word valid |
| ing_in_word | input | 36 | Ingress word |
| ing_vld | output | 1 | Registered ingress valid |
| ing_word | output | 36 | Registered ingress word, with parity applied when enabled |
| eg_in_vld | input | 1 | Egress word valid |
| eg_in_word | input | 36 | Egress word |
| eg_vld | output | 1 | Registered egress valid |
| eg_word | output | 36 | Registered egress word, reversed when enabled |
| eg_lane_err | output | 4 | Per-lane parity failure, indexed by output lane |
| eg_perr | output | 1 | Any-lane parity failure |

## Verification
On the egress path, the parity check and the lane reversal act on the same word in the same cycle. The error vector must therefore land on the mirrored lane position whenever reversal is on. The bench provokes this in two ways. Directed words carry a single corrupted lane, and are sent with reversal off and then on, under both polarities. Random words have lanes with correct parity and occasional single-bit corruption, while reversal and polarity toggle from cycle to cycle. Each registered error bit is compared with a bench model that checks the reversed word lane by lane, and the word itself is compared as well.

// File: rtl/blf_pkg.sv
package blf_pkg;

    localparam int BLF_DEF_LANES = 4;
    localparam int BLF_DEF_DBITS = 8;

    // Polarity helper: given the XOR reduction of some bits, return the bit
    // that makes the total odd (even_sel=0) or even (even_sel=1).
    function automatic logic blf_par_bit(input logic red, input logic even_sel);
        return red ^ ~even_sel;
    endfunction

endpackage

// File: rtl/blf_lane_gen.sv
module blf_lane_gen
    import blf_pkg::*;
#(
    parameter int DBITS = BLF_DEF_DBITS,
    localparam int LW = DBITS + 1
) (
    input  logic [LW-1:0] lane_i,
    input  logic          gen_en_i,
    input  logic          even_i,
    output logic [LW-1:0] lane_o
);

    logic par;

    always_comb begin
        par = blf_par_bit(^lane_i[DBITS-1:0], even_i);
        if (gen_en_i) begin
            lane_o = {par, lane_i[DBITS-1:0]};
        end else begin
            lane_o = lane_i;
        end
    end

endmodule

// File: rtl/blf_lane_chk.sv
module blf_lane_chk
    import blf_pkg::*;
#(
    parameter int DBITS = BLF_DEF_DBITS,
    localparam int LW = DBITS + 1
) (
    input  logic [LW-1:0] lane_i,
    input  logic          even_i,
    output logic          fail_o
);

    // A lane is good when its full ones count matches the polarity;
    // blf_par_bit of the whole lane is then 0.
    always_comb begin
        fail_o = blf_par_bit(^lane_i, even_i);
    end

endmodule

// File: rtl/blf_lane_order.sv
module blf_lane_order #(
    parameter int NLANES = 4,
    parameter int LW     = 9,
    localparam int WW    = NLANES * LW
) (
    input  logic [WW-1:0] word_i,
    input  logic          rev_i,
    output logic [WW-1:0] word_o
);

    for (genvar i = 0; i < NLANES; i++) begin : g_lane
        assign word_o[i*LW +: LW] = rev_i ? word_i[(NLANES-1-i)*LW +: LW]
                                          : word_i[i*LW +: LW];
    end

endmodule

// File: rtl/blf_fmt.sv
module blf_fmt
    import blf_pkg::*;
#(
    parameter int NLANES = BLF_DEF_LANES,
    parameter int DBITS  = BLF_DEF_DBITS
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           cfg_even,
    input  logic                           cfg_gen_en,
    input  logic                           cfg_rev_en,
    input  logic                           ing_in_vld,
    input  logic [NLANES*(DBITS+1)-1:0]    ing_in_word,
    output logic                           ing_vld,
    output logic [NLANES*(DBITS+1)-1:0]    ing_word,
    input  logic                           eg_in_vld,
    input  logic [NLANES*(DBITS+1)-1:0]    eg_in_word,
    output logic                           eg_vld,
    output logic [NLANES*(DBITS+1)-1:0]    eg_word,
    output logic [NLANES-1:0]              eg_lane_err,
    output logic                           eg_perr
);

    localparam int LW = DBITS + 1;
    localparam int WW = NLANES * LW;

    typedef struct packed {
        logic              ing_vld;
        logic [WW-1:0]     ing_word;
        logic              eg_vld;
        logic [WW-1:0]     eg_word;
        logic [NLANES-1:0] eg_err;
        logic              eg_perr;
    } state_t;

    state_t st_d, st_q;

    logic [WW-1:0]     gen_word;
    logic [NLANES-1:0] raw_err;
    logic [WW-1:0]     ord_word;
    logic [NLANES-1:0] ord_err;

    // Ingress parity generation and egress checking, one instance per lane.
    for (genvar l = 0; l < NLANES; l++) begin : g_lane
        blf_lane_gen #(.DBITS(DBITS)) u_gen (
            .lane_i   (ing_in_word[l*LW +: LW]),
            .gen_en_i (cfg_gen_en),
            .even_i   (cfg_even),
            .lane_o   (gen_word[l*LW +: LW])
        );

        blf_lane_chk #(.DBITS(DBITS)) u_chk (
            .lane_i (eg_in_word[l*LW +: LW]),
            .even_i (cfg_even),
            .fail_o (raw_err[l])
        );
    end

    // Word and error vector are reordered by the same lane map.
    blf_lane_order #(.NLANES(NLANES), .LW(LW)) u_ord_word (
        .word_i (eg_in_word),
        .rev_i  (cfg_rev_en),
        .word_o (ord_word)
    );

    blf_lane_order #(.NLANES(NLANES), .LW(1)) u_ord_err (
        .word_i (raw_err),
        .rev_i  (cfg_rev_en),
        .word_o (ord_err)
    );

    always_comb begin
        st_d         = st_q;
        st_d.ing_vld = ing_in_vld;
        st_d.eg_vld  = eg_in_vld;
        if (ing_in_vld) begin
            st_d.ing_word = gen_word;
        end
        if (eg_in_vld) begin
            st_d.eg_word = ord_word;
            st_d.eg_err  = ord_err;
            st_d.eg_perr = |raw_err;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign ing_vld     = st_q.ing_vld;
    assign ing_word    = st_q.ing_word;
    assign eg_vld      = st_q.eg_vld;
    assign eg_word     = st_q.eg_word;
    assign eg_lane_err = st_q.eg_err;
    assign eg_perr     = st_q.eg_perr;

    // ---------------- assertions ----------------

    // R4: ingress valid follows its input by one cycle
    a_r4_ing_latency: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (ing_vld == $past(ing_in_vld)));

    // R4: ingress word holds when nothing was accepted
    a_r4_ing_hold: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$past(ing_in_vld)) |-> $stable(ing_word));

    // R9: egress valid follows its input by one cycle
    a_r9_eg_latency: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (eg_vld == $past(eg_in_vld)));

    // R9: egress outputs hold when nothing was accepted
    a_r9_eg_hold: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$past(eg_in_vld)) |->
            ($stable(eg_word) && $stable(eg_lane_err) && $stable(eg_perr)));

    // R6: combined flag agrees with the lane vector
    a_r6_perr_any: assert property (@(posedge clk) disable iff (!rst_n)
        (eg_perr == (eg_lane_err != '0)));

    // R7: reordering moves lanes but never alters bits
    a_r7_ones_kept: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(eg_in_vld)) |->
            ($countones(eg_word) == $countones($past(eg_in_word))));

    for (genvar l = 0; l < NLANES; l++) begin : g_chk
        // R2: every generated lane meets the polarity that was selected
        a_r2_gen_parity: assert property (@(posedge clk) disable iff (!rst_n)
            ($past(rst_n) && $past(ing_in_vld) && $past(cfg_gen_en)) |->
                ((^ing_word[l*LW +: LW]) == ~$past(cfg_even)));

        // R2: data bits of a lane are never changed by generation
        a_r2_gen_data: assert property (@(posedge clk) disable iff (!rst_n)
            ($past(rst_n) && $past(ing_in_vld)) |->
                (ing_word[l*LW +: DBITS] == $past(ing_in_word[l*LW +: DBITS])));
    end

endmodule

// File: tb/sim_blf_fmt.sv
`timescale 1ns/1ps
module sim_blf_fmt;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_even = 1'b0, cfg_gen_en = 1'b0, cfg_rev_en = 1'b0;
    logic        ing_in_vld = 1'b0, eg_in_vld = 1'b0;
    logic [35:0] ing_in_word = '0, eg_in_word = '0;
    logic        ing_vld, eg_vld, eg_perr;
    logic [35:0] ing_word, eg_word;
    logic [3:0]  eg_lane_err;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    always #4 clk = ~clk;

    blf_fmt u0 (
        .clk, .rst_n, .cfg_even, .cfg_gen_en, .cfg_rev_en,
        .ing_in_vld, .ing_in_word, .ing_vld, .ing_word,
        .eg_in_vld, .eg_in_word, .eg_vld, .eg_word, .eg_lane_err, .eg_perr
    );

    // expected state
    logic        x_ing_vld, x_eg_vld, x_perr;
    logic [35:0] x_ing_word, x_eg_word;
    logic [3:0]  x_err;
    string       x_ing_tag, x_eg_tag;

    function automatic logic [35:0] ref_gen(input logic [35:0] w, input logic even);
        logic [35:0] r = w;
        for (int k = 0; k < 4; k++) begin
            r[9*k+8] = (^w[9*k +: 8]) ^ ~even;
        end
        return r;
    endfunction

    function automatic logic [3:0] ref_fail(input logic [35:0] w, input logic even);
        logic [3:0] f;
        for (int k = 0; k < 4; k++) begin
            f[k] = even ? (^w[9*k +: 9]) : ~(^w[9*k +: 9]);
        end
        return f;
    endfunction

    function automatic logic [35:0] ref_rev(input logic [35:0] w);
        return {w[8:0], w[17:9], w[26:18], w[35:27]};
    endfunction

    task automatic check(input string tag, input logic [35:0] act, input logic [35:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic check_all();
        check({x_ing_tag, " ing_vld R4"}, {35'd0, ing_vld}, {35'd0, x_ing_vld});
        check(x_ing_tag, ing_word, x_ing_word);
        check("R9 eg_vld", {35'd0, eg_vld}, {35'd0, x_eg_vld});
        check(x_eg_tag, eg_word, x_eg_word);
        check("R5 eg_lane_err", {32'd0, eg_lane_err}, {32'd0, x_err});
        check("R6 eg_perr", {35'd0, eg_perr}, {35'd0, x_perr});
    endtask

    // drive one cycle: called just after a negedge check; takes effect at next posedge
    task automatic drive(input logic iv, input logic [35:0] iw,
                         input logic ev, input logic [35:0] ew,
                         input logic even, input logic gen, input logic rev);
        logic [35:0] t;
        ing_in_vld = iv; ing_in_word = iw;
        eg_in_vld = ev;  eg_in_word = ew;
        cfg_even = even; cfg_gen_en = gen; cfg_rev_en = rev;
        x_ing_vld = iv;
        if (iv) begin
            x_ing_word = gen ? ref_gen(iw, even) : iw;
            x_ing_tag  = gen ? "R2 ing_word" : "R3 ing_word";
        end else begin
            x_ing_tag = "R4 ing_word hold";
        end
        x_eg_vld = ev;
        if (ev) begin
            t         = rev ? ref_rev(ew) : ew;
            x_eg_word = t;
            x_err     = ref_fail(t, even);
            x_perr    = |x_err;
            x_eg_tag  = rev ? "R7 eg_word" : "R8 eg_word";
        end else begin
            x_eg_tag = "R9 eg_word hold";
        end
        @(negedge clk);
        check_all();
    endtask

    initial begin
        logic [35:0] good, w;
        void'($urandom(32'h5eed_1234));
        x_ing_vld = 0; x_eg_vld = 0; x_perr = 0;
        x_ing_word = '0; x_eg_word = '0; x_err = '0;
        x_ing_tag = "R1 ing_word"; x_eg_tag = "R1 eg_word";

        // R1: reset state, with inputs active under reset
        ing_in_vld = 1; ing_in_word = '1; eg_in_vld = 1; eg_in_word = 36'h1;
        repeat (3) @(negedge clk);
        check("R1 reset ing_vld", {35'd0, ing_vld}, 36'd0);
        check("R1 reset ing_word", ing_word, 36'd0);
        check("R1 reset eg_vld", {35'd0, eg_vld}, 36'd0);
        check("R1 reset eg_word", eg_word, 36'd0);
        check("R1 reset eg_lane_err", {32'd0, eg_lane_err}, 36'd0);
        check("R1 reset eg_perr", {35'd0, eg_perr}, 36'd0);
        ing_in_vld = 0; eg_in_vld = 0;
        rst_n = 1'b1;
        @(negedge clk);
        check_all();

        // directed: zero word, odd generation -> top bits set
        drive(1, 36'h0, 0, 36'h0, 0, 1, 0);
        check("R2 odd zero word", ing_word, 36'h804020100);
        // even generation on zero word -> unchanged
        drive(1, 36'h0, 0, 36'h0, 1, 1, 0);
        check("R2 even zero word", ing_word, 36'h0);
        // generation off passes top bits
        drive(1, 36'hF_FFFF_FFFF, 0, 36'h0, 0, 0, 0);
        check("R3 passthrough", ing_word, 36'hF_FFFF_FFFF);
        // egress: all lanes good (odd), no reversal
        drive(0, 36'h0, 1, 36'h804020100, 0, 0, 0);
        check("R6 clean word", {35'd0, eg_perr}, 36'd0);
        // single bad lane 0 with reversal -> error on output lane 3
        drive(0, 36'h0, 1, 36'h804020000, 0, 0, 1);
        check("R7 err mirrored", {32'd0, eg_lane_err}, 36'h8);
        drive(0, 36'h0, 1, 36'h804020000, 0, 0, 0);
        check("R5 err lane0", {32'd0, eg_lane_err}, 36'h1);
        // even polarity: zero word is clean, odd word lanes all fail
        drive(0, 36'h0, 1, 36'h0, 1, 0, 1);
        check("R5 even clean", {32'd0, eg_lane_err}, 36'h0);
        drive(0, 36'h0, 1, 36'h804020100, 1, 0, 1);
        check("R6 even all bad", {35'd0, eg_perr}, 36'd1);
        // both paths idle: hold
        drive(0, 36'h123456789, 0, 36'h0, 0, 1, 0);
        drive(0, 36'h0, 0, 36'h0, 1, 0, 1);

        // random, both paths together
        for (int i = 0; i < 600; i++) begin
            logic ev;
            ev = ($urandom % 4) != 0;
            w  = {$urandom, $urandom} & 36'hF_FFFF_FFFF;
            good = ref_gen(w, 1'($urandom));
            if (($urandom % 3) == 0) good[$urandom % 36] ^= 1'b1;
            drive(1'(($urandom % 4) != 0), {$urandom, $urandom} & 36'hF_FFFF_FFFF,
                  ev, (($urandom % 2) != 0) ? good : w,
                  1'($urandom), 1'($urandom), 1'($urandom));
        end

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: actual hung expected done");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

endmodule